// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects interrupt requests from a fixed number of sources and decides which one, if any, is raised to a processor core. Each source has two pieces of state. The first is a pending flag that hardware sets when the source fires. The second is a 3-bit priority level that software programs. A global enable register gates every source. A 3-bit processor priority threshold, driven by the core, sets the level that a request must exceed.

The winning source's index and level are presented on a registered request output. The core answers with a one-cycle acknowledge when it branches to the vector. The controller then clears that source's pending flag. On the next cycle it reports the accepted index and level, so the core can load that level as its new threshold. Software can only clear pending flags. It can never set them.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every pending flag is 0, every level is 000 and the global enable is 0. The request output stays 0 until software programs the block.
- R2: While the global enable register holds 0, no request is raised, whatever the pending flags and levels are.
- R3: A 1 on a source's bit of `src_req` sets that source's pending flag at the next clock edge.
- R4: A software pending write with data 0 clears the addressed flag. A pending write with data 1 has no effect and never sets a flag.
- R5: A source programmed to level 000 is never raised, even when its flag is pending.
- R6: A source is eligible only when its level is strictly greater than `cpu_thr`. A threshold of 111 blocks every source, and a threshold of 000 admits any level from 001 up.
- R7: Among eligible sources the highest level wins. On equal levels the lower source index wins.
- R8: `ack` while `irq_req` is 1 clears the pending flag of the presented source. On the next cycle `acc_vld` is 1, `acc_idx` and `acc_lvl` show the accepted source and level, and that source is no longer presented. `ack` while `irq_req` is 0 is ignored.
- R9: If a hardware set meets a software clear or an acknowledge clear on the same flag in the same cycle, the flag ends up set.
- R10: Level writes, pending writes, enable writes and threshold changes each alter only their own state.
- R11: `irq_req`, `irq_idx` and `irq_lvl` are registered. They reflect the pending, level and enable state of the previous cycle and the threshold sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_req | input | N_SRC | Per-source hardware request, sets pending flag |
| lvl_we | input | 1 | Level write strobe |
| lvl_idx | input | IDX_W | Source addressed by the level write |
| lvl_wdata | input | 3 | New level value |
| pnd_we | input | 1 | Pending write strobe |
| pnd_idx | input | IDX_W | Source addressed by the pending write |
| pnd_wdata | input | 1 | 0 clears the flag, 1 is ignored |
| en_we | input | 1 | Global enable write strobe |
| en_wdata | input | 1 | New global enable value |
| cpu_thr | input | 3 | Processor priority threshold |
| ack | input | 1 | One-cycle acknowledge from the core |
| irq_req | output | 1 | Interrupt request to the core |
| irq_idx | output | IDX_W | Index of the presented source |
| irq_lvl | output | 3 | Level of the presented source |
| acc_vld | output | 1 | Acceptance report valid |
| acc_idx | output | IDX_W | Accepted source index |
| acc_lvl | output | 3 | Accepted level |

## Verification
Some properties are checked on every cycle by assertions. With the enable at 0, the request drops on the next cycle. A presented level always exceeds the threshold sampled at the previous edge. A hardware request always leaves its flag set. A flag that is clear and has no hardware request stays clear. An acknowledge is always followed by a matching acceptance report. Other behaviour depends on the order of events, and only the bench scenarios can show it. These cover the tie-break by index and the effect of level 000. They also cover a write of 1 that sets nothing, and the collision of a hardware set with a clear. Finally, they show that the acknowledged source is not presented again.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_OFF = '0;
  localparam lvl_t LVL_MAX = '1;
endpackage

// File: rtl/prio_irq_bank.sv
module prio_irq_bank
  import prio_irq_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_SRC-1:0]      src_set,
  input  logic                  lvl_we,
  input  logic [IDX_W-1:0]      lvl_idx,
  input  lvl_t                  lvl_wdata,
  input  logic                  pnd_we,
  input  logic [IDX_W-1:0]      pnd_idx,
  input  logic                  pnd_wdata,
  input  logic                  ack_clr,
  input  logic [IDX_W-1:0]      ack_idx,
  input  logic                  en_we,
  input  logic                  en_wdata,
  output logic [N_SRC-1:0]      pend,
  output lvl_t [N_SRC-1:0]      lvl,
  output logic                  glb_en
);

  logic glb_en_nxt;

  always_comb begin
    glb_en_nxt = glb_en;
    if (en_we) glb_en_nxt = en_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) glb_en <= 1'b0;
    else        glb_en <= glb_en_nxt;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic sw_clr;
    logic hw_clr;
    logic pend_nxt;
    lvl_t lvl_nxt;
    logic lvl_hit;

    always_comb begin
      sw_clr   = pnd_we && (pnd_idx == IDX_W'(g)) && !pnd_wdata;
      hw_clr   = ack_clr && (ack_idx == IDX_W'(g));
      // hardware set overrides any clear in the same cycle
      pend_nxt = src_set[g] | (pend[g] & ~sw_clr & ~hw_clr);
      lvl_hit  = lvl_we && (lvl_idx == IDX_W'(g));
      lvl_nxt  = lvl_hit ? lvl_wdata : lvl[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[g] <= 1'b0;
        lvl[g]  <= LVL_OFF;
      end else begin
        pend[g] <= pend_nxt;
        if (lvl_hit) lvl[g] <= lvl_nxt;
      end
    end

    p_hw_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      src_set[g] |=> pend[g]);
    p_no_sw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_set[g] && !pend[g]) |=> !pend[g]);
  end

endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]  pend,
  input  lvl_t [N_SRC-1:0]  lvl,
  input  logic              glb_en,
  input  lvl_t              thr,
  input  logic              mask_vld,
  input  logic [IDX_W-1:0]  mask_idx,
  output logic              win_vld,
  output logic [IDX_W-1:0]  win_idx,
  output lvl_t              win_lvl
);

  logic [N_SRC-1:0] elig;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      elig[i] = glb_en && pend[i] && (lvl[i] > thr) &&
                !(mask_vld && (mask_idx == IDX_W'(i)));
    end
  end

  // ascending scan with strict compare: lower index keeps ties
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_lvl = LVL_OFF;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (lvl[i] > win_lvl)) begin
        win_vld = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl[i];
      end
    end
  end

endmodule

// File: rtl/prio_irq_out.sv
module prio_irq_out
  import prio_irq_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_vld,
  input  logic [IDX_W-1:0]  win_idx,
  input  lvl_t              win_lvl,
  input  logic              ack,
  input  logic              glb_en,
  input  lvl_t              thr,
  output logic              irq_req,
  output logic [IDX_W-1:0]  irq_idx,
  output lvl_t              irq_lvl,
  output logic              acc_vld,
  output logic [IDX_W-1:0]  acc_idx,
  output lvl_t              acc_lvl
);

  logic take;
  logic             req_nxt;
  logic [IDX_W-1:0] idx_nxt;
  lvl_t             lvl_nxt;

  always_comb begin
    take    = ack && irq_req;
    req_nxt = win_vld;
    idx_nxt = win_vld ? win_idx : irq_idx;
    lvl_nxt = win_vld ? win_lvl : irq_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_idx <= '0;
      irq_lvl <= LVL_OFF;
      acc_vld <= 1'b0;
      acc_idx <= '0;
      acc_lvl <= LVL_OFF;
    end else begin
      irq_req <= req_nxt;
      irq_idx <= idx_nxt;
      irq_lvl <= lvl_nxt;
      acc_vld <= take;
      if (take) begin
        acc_idx <= irq_idx;
        acc_lvl <= irq_lvl;
      end
    end
  end

  p_en_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !irq_req);
  p_above_thr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl > $past(thr)));
  p_acc_report_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req) |=> (acc_vld && acc_idx == $past(irq_idx) &&
                          acc_lvl == $past(irq_lvl)));
  p_ack_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && irq_req) |=> !acc_vld);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_req,
  input  logic              lvl_we,
  input  logic [IDX_W-1:0]  lvl_idx,
  input  logic [2:0]        lvl_wdata,
  input  logic              pnd_we,
  input  logic [IDX_W-1:0]  pnd_idx,
  input  logic              pnd_wdata,
  input  logic              en_we,
  input  logic              en_wdata,
  input  logic [2:0]        cpu_thr,
  input  logic              ack,
  output logic              irq_req,
  output logic [IDX_W-1:0]  irq_idx,
  output logic [2:0]        irq_lvl,
  output logic              acc_vld,
  output logic [IDX_W-1:0]  acc_idx,
  output logic [2:0]        acc_lvl
);

  logic [1:0]       rst_sync;
  logic             rst_core_n;
  logic [N_SRC-1:0] pend;
  lvl_t [N_SRC-1:0] lvl;
  logic             glb_en;
  logic             ack_clr;
  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  lvl_t             win_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign ack_clr = ack && irq_req;

  prio_irq_bank #(.N_SRC(N_SRC)) u_bank (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .src_set   (src_req),
    .lvl_we    (lvl_we),
    .lvl_idx   (lvl_idx),
    .lvl_wdata (lvl_wdata),
    .pnd_we    (pnd_we),
    .pnd_idx   (pnd_idx),
    .pnd_wdata (pnd_wdata),
    .ack_clr   (ack_clr),
    .ack_idx   (irq_idx),
    .en_we     (en_we),
    .en_wdata  (en_wdata),
    .pend      (pend),
    .lvl       (lvl),
    .glb_en    (glb_en)
  );

  prio_irq_arb #(.N_SRC(N_SRC)) u_arb (
    .pend     (pend),
    .lvl      (lvl),
    .glb_en   (glb_en),
    .thr      (cpu_thr),
    .mask_vld (ack_clr),
    .mask_idx (irq_idx),
    .win_vld  (win_vld),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  prio_irq_out #(.N_SRC(N_SRC)) u_out (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .win_vld (win_vld),
    .win_idx (win_idx),
    .win_lvl (win_lvl),
    .ack     (ack),
    .glb_en  (glb_en),
    .thr     (cpu_thr),
    .irq_req (irq_req),
    .irq_idx (irq_idx),
    .irq_lvl (irq_lvl),
    .acc_vld (acc_vld),
    .acc_idx (acc_idx),
    .acc_lvl (acc_lvl)
  );

  // R8: the presented source is not presented again right after its acknowledge
  p_no_repeat_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ack && irq_req && !src_req[irq_idx]) |=> !(irq_req && irq_idx == $past(irq_idx)));

endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_req = '0;
  logic          lvl_we = 1'b0;
  logic [IW-1:0] lvl_idx = '0;
  logic [2:0]    lvl_wdata = '0;
  logic          pnd_we = 1'b0;
  logic [IW-1:0] pnd_idx = '0;
  logic          pnd_wdata = 1'b0;
  logic          en_we = 1'b0;
  logic          en_wdata = 1'b0;
  logic [2:0]    cpu_thr = '0;
  logic          ack = 1'b0;
  logic          irq_req, acc_vld;
  logic [IW-1:0] irq_idx, acc_idx;
  logic [2:0]    irq_lvl, acc_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N)) u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .lvl_we(lvl_we), .lvl_idx(lvl_idx), .lvl_wdata(lvl_wdata),
    .pnd_we(pnd_we), .pnd_idx(pnd_idx), .pnd_wdata(pnd_wdata),
    .en_we(en_we), .en_wdata(en_wdata), .cpu_thr(cpu_thr), .ack(ack),
    .irq_req(irq_req), .irq_idx(irq_idx), .irq_lvl(irq_lvl),
    .acc_vld(acc_vld), .acc_idx(acc_idx), .acc_lvl(acc_lvl));

  // reference state kept by the bench
  logic [N-1:0]  m_pend;
  logic [2:0]    m_lvl [N];
  logic          m_en;
  logic          m_req, m_accv;
  logic [IW-1:0] m_idx, m_acci;
  logic [2:0]    m_ilvl, m_accl;

  // pick: bit 6 valid, [5:3] index, [2:0] level
  function automatic logic [6:0] pick(input logic [N-1:0] p, input logic en,
                                      input logic [2:0] thr, input logic mv,
                                      input logic [IW-1:0] mi);
    logic [6:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (en && p[i] && m_lvl[i] > thr && !(mv && mi == IW'(i)) &&
          (!r[6] || m_lvl[i] >= r[2:0]))
        r = {1'b1, IW'(i), m_lvl[i]};
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= '0; m_en <= 1'b0; m_req <= 1'b0; m_idx <= '0; m_ilvl <= '0;
      m_accv <= 1'b0; m_acci <= '0; m_accl <= '0;
      for (int i = 0; i < N; i++) m_lvl[i] <= '0;
    end else begin
      logic [6:0] w;
      logic tk;
      tk = ack && m_req;
      w = pick(m_pend, m_en, cpu_thr, tk, m_idx);
      m_req <= w[6];
      if (w[6]) begin m_idx <= w[5:3]; m_ilvl <= w[2:0]; end
      m_accv <= tk;
      if (tk) begin m_acci <= m_idx; m_accl <= m_ilvl; end
      for (int i = 0; i < N; i++) begin
        logic clr;
        clr = (pnd_we && pnd_idx == IW'(i) && !pnd_wdata) || (tk && m_idx == IW'(i));
        m_pend[i] <= src_req[i] || (m_pend[i] && !clr);
        if (lvl_we && lvl_idx == IW'(i)) m_lvl[i] <= lvl_wdata;
      end
      if (en_we) m_en <= en_wdata;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // compare all outputs against the reference, at the falling edge
  task automatic cmp(input string tag);
    chk(tag, "irq_req", irq_req, m_req);
    if (m_req) begin
      chk(tag, "irq_idx", irq_idx, m_idx);
      chk(tag, "irq_lvl", irq_lvl, m_ilvl);
    end
    chk(tag, "acc_vld", acc_vld, m_accv);
    if (m_accv) begin
      chk(tag, "acc_idx", acc_idx, m_acci);
      chk(tag, "acc_lvl", acc_lvl, m_accl);
    end
  endtask

  task automatic idle();
    src_req = '0; lvl_we = 0; pnd_we = 0; en_we = 0; ack = 0;
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    cmp(tag);
  endtask

  task automatic wr_lvl(input int i, input int v, input string tag);
    idle(); lvl_we = 1; lvl_idx = IW'(i); lvl_wdata = 3'(v);
    step(tag);
  endtask

  task automatic wr_pnd(input int i, input bit v, input string tag);
    idle(); pnd_we = 1; pnd_idx = IW'(i); pnd_wdata = v;
    step(tag);
  endtask

  task automatic wr_en(input bit v, input string tag);
    idle(); en_we = 1; en_wdata = v;
    step(tag);
  endtask

  task automatic fire(input logic [N-1:0] m, input string tag);
    idle(); src_req = m;
    step(tag);
  endtask

  task automatic settle(input string tag);
    idle(); step(tag); step(tag);
  endtask

  task automatic clear_all(input string tag);
    for (int i = 0; i < N; i++) wr_pnd(i, 1'b0, tag);
    settle(tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1c0d));
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "irq_req after reset", irq_req, 0);
    chk("R1", "acc_vld after reset", acc_vld, 0);
    fire(8'hFF, "R1");
    settle("R1");
    chk("R1", "irq_req with reset levels and enable", irq_req, 0);
    // R5: level 000 pending but enabled
    wr_en(1, "R5");
    settle("R5");
    chk("R5", "irq_req at level 000", irq_req, 0);
    clear_all("R4");
    // R3, R11: hardware set, one cycle to pend, one to request
    wr_lvl(3, 4, "R10");
    settle("R10");
    chk("R10", "level write alone raises nothing", irq_req, 0);
    idle(); src_req = 8'h08;
    @(negedge clk); chk("R11", "irq_req one cycle after set", irq_req, 0);
    idle();
    @(negedge clk); chk("R3", "irq_req two cycles after set", irq_req, 1);
    chk("R3", "irq_idx", irq_idx, 3);
    chk("R3", "irq_lvl", irq_lvl, 4);
    // R6: threshold equal blocks, lower passes, 111 blocks
    cpu_thr = 3'd4; settle("R6");
    chk("R6", "irq_req level equal threshold", irq_req, 0);
    cpu_thr = 3'd3; settle("R6");
    chk("R6", "irq_req level above threshold", irq_req, 1);
    wr_lvl(3, 7, "R6");
    cpu_thr = 3'd7; settle("R6");
    chk("R6", "irq_req threshold 111", irq_req, 0);
    cpu_thr = 3'd0; wr_lvl(3, 1, "R6"); settle("R6");
    chk("R6", "irq_req level 1 threshold 0", irq_req, 1);
    // R2: enable off blocks, pending kept (R10)
    wr_en(0, "R2"); settle("R2");
    chk("R2", "irq_req enable 0", irq_req, 0);
    wr_en(1, "R10"); settle("R10");
    chk("R10", "pending kept across enable write", irq_req, 1);
    // R4: clear by 0, write 1 ignored
    wr_pnd(3, 1'b0, "R4"); settle("R4");
    chk("R4", "irq_req after clear", irq_req, 0);
    wr_pnd(3, 1'b1, "R4"); settle("R4");
    chk("R4", "irq_req after write of 1", irq_req, 0);
    // R7: priority and tie
    wr_lvl(1, 5, "R7"); wr_lvl(5, 5, "R7"); wr_lvl(6, 2, "R7");
    fire(8'h62, "R7"); settle("R7");
    chk("R7", "tie lower index", irq_idx, 1);
    wr_lvl(6, 6, "R7"); settle("R7");
    chk("R7", "highest level wins", irq_idx, 6);
    // R8: acknowledge chain
    idle(); ack = 1; step("R8");
    idle(); step("R8");
    chk("R8", "acc_idx", acc_idx, 6);
    chk("R8", "acc_lvl", acc_lvl, 6);
    chk("R8", "next presented", irq_idx, 1);
    idle(); ack = 1; step("R8");
    idle(); step("R8");
    chk("R8", "second acc_idx", acc_idx, 1);
    chk("R8", "then index 5", irq_idx, 5);
    idle(); ack = 1; step("R8"); idle(); settle("R8");
    chk("R8", "all acknowledged", irq_req, 0);
    idle(); ack = 1; step("R8"); idle(); step("R8");
    chk("R8", "ack while idle ignored", acc_vld, 0);
    // R9: hardware set against software clear and acknowledge clear
    fire(8'h02, "R9"); settle("R9");
    idle(); pnd_we = 1; pnd_idx = 3'd1; pnd_wdata = 0; src_req = 8'h02;
    step("R9"); settle("R9");
    chk("R9", "set beats sw clear", irq_req, 1);
    idle(); ack = 1; src_req = 8'h02; step("R9"); settle("R9");
    chk("R9", "set beats ack clear", irq_req, 1);
    chk("R9", "same source again", irq_idx, 1);
    clear_all("R4");
    // random phase
    for (int c = 0; c < 4000; c++) begin
      idle();
      if ($urandom % 6 == 0) src_req = N'(1 << ($urandom % N));
      if ($urandom % 4 == 0) begin
        lvl_we = 1; lvl_idx = IW'($urandom); lvl_wdata = 3'($urandom);
      end
      if ($urandom % 5 == 0) begin
        pnd_we = 1; pnd_idx = IW'($urandom); pnd_wdata = 1'($urandom);
      end
      if ($urandom % 40 == 0) begin en_we = 1; en_wdata = ($urandom % 4) != 0; end
      if ($urandom % 15 == 0) cpu_thr = ($urandom % 3 == 0) ? 3'($urandom) : 3'($urandom % 3);
      if (m_req && ($urandom % 2 == 0)) ack = 1;
      step("R7");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule